// File: doc/BRIEF.md
# Ones-Density Offset and Gain Calibrator

This block is a host-side sequencer that calibrates a 1-bit sigma-delta modulator. A start command makes it reset the modulator first. It then raises the modulator's zero-input line, waits for the loop to settle, and counts the ones in a fixed window of bitstream bits. Next it drops that line, raises the gain-calibrate line, and again waits and counts. The bitstream is sampled on rising edges of the modulator's serial clock. Every settle, reset and window length is counted in those edges, and each edge stands for one master-clock period of the modulator.

Each measured ones count is reported with a signed error against the ideal count. The ideal count is window/2 for offset in bipolar mode, 3·window/8 for offset in unipolar mode, and 5·window/8 for gain. The window is a power of two, so all three ideal counts are exact integers. The polarity mode is captured when calibration starts. The results only hold for that mode, so a later mode change raises a stale flag that stays up until a fresh calibration finishes.

Top module: `ones_cal_ctrl`

## Requirements
- R1: After reset all three control lines, busy, done, cal_valid and stale are low, and both counts and both errors are zero.
- R2: An accepted start first drives mod_reset high for RST_EDGES serial-clock rising edges. zero_in only rises in the cycle directly after mod_reset was high.
- R3: At most one of mod_reset, zero_in and gain_cal is high at any time. There is at least one clock cycle with all of them low between zero_in falling and gain_cal rising.
- R4: After zero_in or gain_cal rises, the first SETTLE serial-clock rising edges are not counted. The following 2^LOG2_WIN edges are counted.
- R5: off_count is the number of ones sampled on serial-clock rising edges in the offset window. It covers the full range 0 to 2^LOG2_WIN. off_err = off_count − ideal, where ideal is 2^LOG2_WIN/2 when the mode captured at start is bipolar (bipolar = 1) and 3·2^LOG2_WIN/8 when it is unipolar (bipolar = 0).
- R6: gain_count is the number of ones in the gain window, and gain_err = gain_count − 5·2^LOG2_WIN/8.
- R7: Completion is a done pulse exactly one cycle wide. In the cycle after it, busy is low and cal_valid is high. cal_valid is low from an accepted start until completion.
- R8: A start pulse while busy is high is ignored: mod_reset does not rise again during that run.
- R9: When cal_valid is high and bipolar differs from the mode captured at start, stale goes high and stays high even if the mode is restored. Only the done pulse of a later calibration clears it, in the cycle after done. The same rule then applies again, so a mode flipped during the run raises stale one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, faster than bit_sclk |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Calibration request, accepted when idle |
| bipolar | input | 1 | Input mode: 1 bipolar, 0 unipolar |
| bit_sclk | input | 1 | Modulator serial clock |
| bit_data | input | 1 | Modulator bitstream, valid at bit_sclk rise |
| mod_reset | output | 1 | Modulator reset line |
| zero_in | output | 1 | Modulator zero-input (offset) line |
| gain_cal | output | 1 | Modulator gain-calibrate line |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| cal_valid | output | 1 | Results belong to a finished calibration |
| stale | output | 1 | Mode changed since results were taken |
| off_count | output | LOG2_WIN+1 | Ones counted in the offset window |
| off_err | output | LOG2_WIN+2 | Signed offset error vs ideal |
| gain_count | output | LOG2_WIN+1 | Ones counted in the gain window |
| gain_err | output | LOG2_WIN+2 | Signed gain error vs ideal |

## Verification
Two functions can act on the stale flag in the same cycle. One is the completion of a calibration, which clears it. The other is the mode comparison, which sets it. The bench provokes this by flipping bipolar in the middle of a run, so that the mismatch already exists when done fires. It then expects stale low in the cycle after done and high from the next cycle on, with both errors still computed against the mode captured at start. A second case shows that completion alone clears the sticky flag: the mode is flipped and then restored, stale stays high, and only a fresh run brings it down.

// File: rtl/ones_cal_pkg.sv
package ones_cal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RESET, ST_OFF_SETTLE, ST_OFF_COUNT,
    ST_BREAK, ST_GAIN_SETTLE, ST_GAIN_COUNT, ST_DONE
  } cal_state_t;

  // Ideal ones in a window of 'win' bits with the offset input applied.
  function automatic int unsigned ideal_offset(input logic bip, input int unsigned win);
    return bip ? (win / 2) : ((win * 3) / 8);
  endfunction

  // Ideal ones in a window of 'win' bits with the gain input applied.
  function automatic int unsigned ideal_gain(input int unsigned win);
    return (win * 5) / 8;
  endfunction

endpackage

// File: rtl/cal_sclk_sync.sv
module cal_sclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic data_in,
  output logic bit_evt,
  output logic bit_val
);
  logic [STAGES-1:0] s_pipe;
  logic [STAGES-1:0] d_pipe;
  logic              s_last;

  // Clock and data share one pipeline depth so the sampled bit lines up with the edge.
  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s_pipe <= '0;
          d_pipe <= '0;
        end else begin
          s_pipe <= sclk_in;
          d_pipe <= data_in;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s_pipe <= '0;
          d_pipe <= '0;
        end else begin
          s_pipe <= {s_pipe[STAGES-2:0], sclk_in};
          d_pipe <= {d_pipe[STAGES-2:0], data_in};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_last <= 1'b0;
    else        s_last <= s_pipe[STAGES-1];
  end

  assign bit_evt = s_pipe[STAGES-1] & ~s_last;
  assign bit_val = d_pipe[STAGES-1];
endmodule

// File: rtl/cal_phase_timer.sv
module cal_phase_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  input  logic [TW-1:0] limit,
  output logic          hit
);
  logic [TW-1:0] cnt;

  assign hit = step && (cnt == limit - TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (step)  cnt <= cnt + TW'(1);
  end
endmodule

// File: rtl/cal_ones_tally.sv
module cal_ones_tally #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          en,
  input  logic          bit_in,
  output logic [CW-1:0] total
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             total <= '0;
    else if (clear)         total <= '0;
    else if (en && bit_in)  total <= total + CW'(1);
  end
endmodule

// File: rtl/ones_cal_ctrl.sv
module ones_cal_ctrl
  import ones_cal_pkg::*;
#(
  parameter int RST_EDGES   = 20,
  parameter int SETTLE      = 1000,
  parameter int LOG2_WIN    = 12,
  parameter int SYNC_STAGES = 2,
  localparam int WIN  = 1 << LOG2_WIN,
  localparam int CW   = LOG2_WIN + 1,
  localparam int MAXL = (SETTLE > WIN) ? ((SETTLE > RST_EDGES) ? SETTLE : RST_EDGES)
                                       : ((WIN > RST_EDGES) ? WIN : RST_EDGES),
  localparam int TW   = $clog2(MAXL + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 bipolar,
  input  logic                 bit_sclk,
  input  logic                 bit_data,
  output logic                 mod_reset,
  output logic                 zero_in,
  output logic                 gain_cal,
  output logic                 busy,
  output logic                 done,
  output logic                 cal_valid,
  output logic                 stale,
  output logic [CW-1:0]        off_count,
  output logic signed [CW:0]   off_err,
  output logic [CW-1:0]        gain_count,
  output logic signed [CW:0]   gain_err
);
  localparam logic [CW-1:0] IDEAL_OFF_BIP = CW'(ideal_offset(1'b1, WIN));
  localparam logic [CW-1:0] IDEAL_OFF_UNI = CW'(ideal_offset(1'b0, WIN));
  localparam logic [CW-1:0] IDEAL_GAIN    = CW'(ideal_gain(WIN));

  function automatic logic signed [CW:0] count_diff(input logic [CW-1:0] meas,
                                                    input logic [CW-1:0] ideal);
    return $signed({1'b0, meas}) - $signed({1'b0, ideal});
  endfunction

  cal_state_t    state;
  logic          cal_mode;
  logic          stale_q;

  // Named internal events, brought out for the checker and for reading.
  logic          bit_evt;
  logic          bit_val;
  logic          timed_phase;
  logic          count_phase;
  logic          settle_phase;
  logic          phase_end;
  logic          tm_hit;
  logic          tm_clr;
  logic          start_acc;
  logic [TW-1:0] tm_limit;
  logic [CW-1:0] tally;
  logic [CW-1:0] final_cnt;

  cal_sclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk_in(bit_sclk), .data_in(bit_data),
    .bit_evt(bit_evt), .bit_val(bit_val)
  );

  assign settle_phase = (state == ST_OFF_SETTLE) || (state == ST_GAIN_SETTLE);
  assign count_phase  = (state == ST_OFF_COUNT)  || (state == ST_GAIN_COUNT);
  assign timed_phase  = settle_phase || count_phase || (state == ST_RESET);
  assign phase_end    = timed_phase && tm_hit;
  assign start_acc    = start && (state == ST_IDLE);
  assign tm_clr       = phase_end || (state == ST_IDLE) || (state == ST_BREAK);

  always_comb begin
    unique case (state)
      ST_RESET:                      tm_limit = TW'(RST_EDGES);
      ST_OFF_SETTLE, ST_GAIN_SETTLE: tm_limit = TW'(SETTLE);
      default:                       tm_limit = TW'(WIN);
    endcase
  end

  cal_phase_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(tm_clr), .step(bit_evt && timed_phase),
    .limit(tm_limit), .hit(tm_hit)
  );

  cal_ones_tally #(.CW(CW)) u_tally (
    .clk(clk), .rst_n(rst_n), .clear(phase_end && settle_phase),
    .en(bit_evt && count_phase), .bit_in(bit_val), .total(tally)
  );

  // Count including the bit that arrives with the window's last edge.
  assign final_cnt = tally + CW'(bit_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cal_mode   <= 1'b0;
      cal_valid  <= 1'b0;
      off_count  <= '0;
      off_err    <= '0;
      gain_count <= '0;
      gain_err   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start_acc) begin
          state     <= ST_RESET;
          cal_mode  <= bipolar;
          cal_valid <= 1'b0;
        end
        ST_RESET:       if (phase_end) state <= ST_OFF_SETTLE;
        ST_OFF_SETTLE:  if (phase_end) state <= ST_OFF_COUNT;
        ST_OFF_COUNT: if (phase_end) begin
          state     <= ST_BREAK;
          off_count <= final_cnt;
          off_err   <= count_diff(final_cnt, cal_mode ? IDEAL_OFF_BIP : IDEAL_OFF_UNI);
        end
        ST_BREAK:       state <= ST_GAIN_SETTLE;
        ST_GAIN_SETTLE: if (phase_end) state <= ST_GAIN_COUNT;
        ST_GAIN_COUNT: if (phase_end) begin
          state      <= ST_DONE;
          gain_count <= final_cnt;
          gain_err   <= count_diff(final_cnt, IDEAL_GAIN);
          cal_valid  <= 1'b1;
        end
        default:        state <= ST_IDLE;
      endcase
    end
  end

  // Completion wins over a mismatch in the same cycle; the mismatch re-raises next cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                stale_q <= 1'b0;
    else if (state == ST_DONE) stale_q <= 1'b0;
    else if (cal_valid && (bipolar != cal_mode)) stale_q <= 1'b1;
  end

  assign mod_reset = (state == ST_RESET);
  assign zero_in   = (state == ST_OFF_SETTLE) || (state == ST_OFF_COUNT);
  assign gain_cal  = (state == ST_GAIN_SETTLE) || (state == ST_GAIN_COUNT);
  assign busy      = (state != ST_IDLE) && (state != ST_DONE);
  assign done      = (state == ST_DONE);
  assign stale     = stale_q;
endmodule

// File: rtl/ones_cal_ctrl_chk.sv
module ones_cal_ctrl_chk #(
  parameter int CW  = 13,
  parameter int WIN = 4096
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mod_reset,
  input logic          zero_in,
  input logic          gain_cal,
  input logic          busy,
  input logic          done,
  input logic          cal_valid,
  input logic          stale,
  input logic [CW-1:0] off_count,
  input logic [CW-1:0] gain_count
);
  AST_CTRL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mod_reset, zero_in, gain_cal})); // R3
  AST_GAIN_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gain_cal) |-> $past(!zero_in)); // R3
  AST_RESET_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zero_in) |-> $past(mod_reset)); // R2
  AST_RESET_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_reset) |-> $past(!busy)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (cal_valid && !busy)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (off_count <= CW'(WIN)) && (gain_count <= CW'(WIN))); // R5
  AST_STALE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !stale); // R9
endmodule

bind ones_cal_ctrl ones_cal_ctrl_chk #(.CW(CW), .WIN(WIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .mod_reset(mod_reset), .zero_in(zero_in),
  .gain_cal(gain_cal), .busy(busy), .done(done), .cal_valid(cal_valid),
  .stale(stale), .off_count(off_count), .gain_count(gain_count)
);

// File: tb/ones_cal_ctrl_test.sv
`timescale 1ns/1ps
module ones_cal_ctrl_test;
  localparam int RST_E  = 4;
  localparam int SET    = 24;
  localparam int L2W    = 6;
  localparam int W      = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic bipolar = 1'b1;
  logic bit_sclk = 1'b0;
  logic bit_data = 1'b0;
  logic mod_reset, zero_in, gain_cal, busy, done, cal_valid, stale;
  logic [L2W:0] off_count, gain_count;
  logic signed [L2W+1:0] off_err, gain_err;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  int k_off = 32;
  int k_gain = 40;
  int rst_rises = 0;
  int seq_bad = 0;
  int done_len_bad = 0;

  always #4 clk = ~clk;

  ones_cal_ctrl #(.RST_EDGES(RST_E), .SETTLE(SET), .LOG2_WIN(L2W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .bipolar(bipolar),
    .bit_sclk(bit_sclk), .bit_data(bit_data), .mod_reset(mod_reset),
    .zero_in(zero_in), .gain_cal(gain_cal), .busy(busy), .done(done),
    .cal_valid(cal_valid), .stale(stale), .off_count(off_count),
    .off_err(off_err), .gain_count(gain_count), .gain_err(gain_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // Modulator model: density k/W from a wrapping accumulator, ones while settling.
  initial begin : modulator
    int cur, prevc, since, acc;
    prevc = 3; since = 0; acc = 0;
    #8;
    forever begin
      #16 bit_sclk = 1'b1;
      #16 bit_sclk = 1'b0;
      cur = mod_reset ? 0 : (zero_in ? 1 : (gain_cal ? 2 : 3));
      if (cur != prevc) since = 0; else since++;
      prevc = cur;
      if (cur == 1 || cur == 2) begin
        if (since < SET - 8) bit_data = 1'b1;
        else begin
          acc += (cur == 1) ? k_off : k_gain;
          if (acc >= W) begin bit_data = 1'b1; acc -= W; end
          else bit_data = 1'b0;
        end
      end else bit_data = 1'b0;
    end
  end

  // Sequence monitor, sampled on the falling clock edge.
  always @(negedge clk) begin : monitor
    logic pm, pz, pg, pd;
    if (rst_n) begin
      if (int'(mod_reset) + int'(zero_in) + int'(gain_cal) > 1) seq_bad++;
      if (gain_cal && !pg && pz) seq_bad++;
      if (zero_in && !pz && !pm) seq_bad++;
      if (mod_reset && !pm) rst_rises++;
      if (done && pd) done_len_bad++;
    end
    pm = mod_reset; pz = zero_in; pg = gain_cal; pd = done;
  end

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
    chk(ok, "R7 done within limit", int'(ok), 1);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run_cal(input bit bip, input int ko, input int kg, input string tag);
    bit ok;
    int ideal_o, ideal_g;
    ideal_o = bip ? (W >> 1) : (W >> 3) * 3;
    ideal_g = (W >> 3) * 5;
    bipolar = bip; k_off = ko; k_gain = kg; rst_rises = 0;
    pulse_start();
    chk(busy && !cal_valid, {"R7 busy, valid low after start ", tag}, int'(busy), 1);
    wait_done(ok);
    chk(int'(off_count) == ko, {"R5 offset count ", tag}, int'(off_count), ko);
    chk(int'(off_err) == ko - ideal_o, {"R5 offset error ", tag}, int'(off_err), ko - ideal_o);
    chk(int'(gain_count) == kg, {"R6 gain count ", tag}, int'(gain_count), kg);
    chk(int'(gain_err) == kg - ideal_g, {"R6 gain error ", tag}, int'(gain_err), kg - ideal_g);
    chk(rst_rises == 1, {"R2 single reset phase ", tag}, rst_rises, 1);
    chk(seq_bad == 0, {"R3 control exclusivity/gap ", tag}, seq_bad, 0);
    @(negedge clk);
    chk(!busy && cal_valid && !done, {"R7 idle and valid after done ", tag}, int'(cal_valid), 1);
    chk(done_len_bad == 0, {"R7 done one cycle ", tag}, done_len_bad, 0);
  endtask

  task automatic t_reset_state();
    chk(!mod_reset && !zero_in && !gain_cal, "R1 controls low", int'(mod_reset), 0);
    chk(!busy && !done && !cal_valid && !stale, "R1 flags low", int'(busy), 0);
    chk(off_count == 0 && gain_count == 0 && off_err == 0 && gain_err == 0,
        "R1 results zero", int'(off_count), 0);
  endtask

  task automatic t_start_busy();
    bit ok;
    bipolar = 1'b1; k_off = 30; k_gain = 41; rst_rises = 0;
    pulse_start();
    wait (zero_in == 1'b1);
    pulse_start();
    wait (gain_cal == 1'b1);
    pulse_start();
    wait_done(ok);
    chk(rst_rises == 1, "R8 start while busy ignored", rst_rises, 1);
    chk(int'(off_count) == 30 && int'(gain_count) == 41, "R8 run unchanged",
        int'(off_count), 30);
    repeat (3) @(negedge clk);
    chk(!busy && !mod_reset, "R8 no restart after done", int'(busy), 0);
  endtask

  task automatic t_stale();
    bit ok;
    chk(!stale, "R9 fresh results not stale", int'(stale), 0);
    bipolar = ~bipolar;
    repeat (2) @(negedge clk);
    chk(stale, "R9 stale after mode change", int'(stale), 1);
    bipolar = ~bipolar;
    repeat (3) @(negedge clk);
    chk(stale, "R9 stale sticky after restore", int'(stale), 1);
    run_cal(1'b1, 32, 40, "stale clear");
    chk(!stale, "R9 cleared by completion", int'(stale), 0);
    // Mode flipped mid-run: results use the start mode, stale rises after done.
    k_off = 24; k_gain = 40; bipolar = 1'b0; rst_rises = 0;
    pulse_start();
    wait (gain_cal == 1'b1);
    @(negedge clk); bipolar = 1'b1;
    wait_done(ok);
    chk(int'(off_err) == 0, "R9 ideal from start mode", int'(off_err), 0);
    @(negedge clk);
    chk(!stale, "R9 low in cycle after done", int'(stale), 1'b0);
    @(negedge clk);
    chk(stale, "R9 high one cycle later", int'(stale), 1);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset_state();
    run_cal(1'b1, 32, 40, "bipolar ideal");        // R4 settle ones excluded
    run_cal(1'b0, 24, 40, "unipolar ideal");       // R4
    run_cal(1'b1, 29, 45, "bipolar skewed");
    run_cal(1'b0, 27, 37, "unipolar skewed");
    run_cal(1'b1, 64, 0, "full and empty window");
    run_cal(1'b0, 0, 64, "empty and full window");
    t_start_busy();
    t_stale();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule